// File: doc/BRIEF.md
# Programmable Priority Slave-Port Arbiter

This block chooses which of several bus masters may own a single slave port. Every master carries a small priority value held in a configuration register inside the block. Whenever the port is free, the arbiter compares the values of all masters that are currently requesting and grants the port to the one with the largest value. A value of zero takes a master out of contention for this port altogether.

Once a master holds the grant, the grant stays with it until that master signals that its transaction has finished. On that same edge the arbiter picks the next owner from the requests present at that moment, so there is no idle cycle between owners. Software may rewrite the priority register at any time. A write made while a transaction is open changes nothing until the next arbitration. The configuration register resets to non-zero values, so the port can be arbitrated without any software setup.

Top module: `prio_slave_arb`

## Requirements
- R1: After reset, `gnt_o` is all zeros and `gnt_vld_o` is 0. The priority register reads back with master i set to i+1 (for 4 masters with 3-bit fields, `prio_o` = 12'b100_011_010_001), where master i's field is bits [3i+2:3i].
- R2: While the port is free, the requesting master with a non-zero priority is granted one clock edge after its request is sampled. `gnt_o` is one-hot with bit i meaning master i, and `gnt_vld_o` = 1.
- R3: A master whose priority field is 0 is never granted, even when it is the only requester.
- R4: When two or more eligible requesters share the highest priority value, the one with the lowest index is granted.
- R5: A grant is held for as long as the granted master keeps `done_i` low. Done bits of other masters, and new requests from higher-priority masters, do not change the grant.
- R6: On the edge where the granted master's `done_i` bit is 1, the arbiter grants the best eligible requester present at that edge, with no idle cycle between owners.
- R7: When no eligible master is requesting at an arbitration edge, `gnt_vld_o` is 0 and `gnt_o` is all zeros.
- R8: A write to the priority register, made by setting `cfg_we_i` for one edge, is visible on `prio_o` after that edge. During an open grant the write does not change the current owner. The new values apply from the next arbitration.
- R9: `gnt_o` never has more than one bit set, and `gnt_vld_o` is 1 exactly when `gnt_o` is non-zero.
- R10: Priorities are compared as unsigned numbers: a larger field value wins over a smaller one, whatever the master index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N_MST | Request per master |
| done_i | input | N_MST | End-of-transaction flag per master; only the current owner's bit is used |
| cfg_we_i | input | 1 | Write enable for the priority register |
| cfg_prio_i | input | N_MST*PRIO_W | New packed priority fields, master i at [PRIO_W*i +: PRIO_W] |
| prio_o | output | N_MST*PRIO_W | Current contents of the priority register |
| gnt_o | output | N_MST | Registered one-hot grant |
| gnt_vld_o | output | 1 | Registered flag that a grant is active |

## Verification
The embedded assertions check on every cycle that the grant is one-hot with a matching valid flag (R9), and that an open grant stays put until its owner's done bit arrives (R5). They also check that each new grant goes to a master that was requesting with a non-zero priority on the previous edge (R2, R3), and that the valid flag stays low when nobody eligible asked (R7). Which master wins a given compare can only be shown by the bench's directed scenarios. This covers the ordering by value (R10), the low-index tie rule (R4), the back-to-back handover (R6), the reset defaults (R1) and the deferred effect of a register write during a hold (R8).

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  // Index of the lowest set bit of a one-hot or zero vector, width up to 32.
  function automatic int unsigned onehot_to_idx(input logic [31:0] vec);
    int unsigned idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (vec[i]) idx = i;
    end
    return idx;
  endfunction
endpackage

// File: rtl/prio_cfg_reg.sv
module prio_cfg_reg #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we_i,
  input  logic [N_MST*PRIO_W-1:0] wdata_i,
  output logic [N_MST*PRIO_W-1:0] prio_o
);
  // One field per master; the reset value of master i is i+1.
  for (genvar g = 0; g < N_MST; g++) begin : g_field
    localparam logic [PRIO_W-1:0] RST_VAL = PRIO_W'(g + 1);
    logic [PRIO_W-1:0] field_q;
    always_ff @(posedge clk) begin
      if (rst)       field_q <= RST_VAL;
      else if (we_i) field_q <= wdata_i[g*PRIO_W +: PRIO_W];
    end
    assign prio_o[g*PRIO_W +: PRIO_W] = field_q;
  end

  // A write lands on the next edge (R8).
  assert_cfg_write_R8: assert property (@(posedge clk) disable iff (rst)
    we_i |=> prio_o == $past(wdata_i));
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 3
) (
  input  logic [N_MST-1:0]        req_i,
  input  logic [N_MST*PRIO_W-1:0] prio_i,
  output logic [N_MST-1:0]        elig_o,
  output logic [N_MST-1:0]        win_o,
  output logic                    win_vld_o
);
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1;

  // A master competes only when it requests with a non-zero field (R3).
  for (genvar g = 0; g < N_MST; g++) begin : g_elig
    assign elig_o[g] = req_i[g] && (prio_i[g*PRIO_W +: PRIO_W] != '0);
  end

  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_val;

  // Ascending scan with strict compare: equal values keep the lower index (R4).
  always_comb begin
    best_idx  = '0;
    best_val  = '0;
    win_vld_o = 1'b0;
    for (int i = 0; i < N_MST; i++) begin
      if (elig_o[i] && (prio_i[i*PRIO_W +: PRIO_W] > best_val)) begin
        best_val  = prio_i[i*PRIO_W +: PRIO_W];
        best_idx  = IDX_W'(i);
        win_vld_o = 1'b1;
      end
    end
    win_o = '0;
    if (win_vld_o) win_o[best_idx] = 1'b1;
  end
endmodule

// File: rtl/grant_hold.sv
module grant_hold #(
  parameter int N_MST = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_MST-1:0] win_i,
  input  logic             win_vld_i,
  input  logic [N_MST-1:0] done_i,
  output logic [N_MST-1:0] gnt_o,
  output logic             gnt_vld_o
);
  logic owner_done;
  logic arb_slot;

  assign owner_done = |(done_i & gnt_o);
  assign arb_slot   = !gnt_vld_o || owner_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_o     <= '0;
      gnt_vld_o <= 1'b0;
    end else if (arb_slot) begin
      gnt_o     <= win_vld_i ? win_i : '0;
      gnt_vld_o <= win_vld_i;
    end
  end

  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o) && (gnt_vld_o == (gnt_o != '0)));

  assert_grant_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (gnt_vld_o && !(|(done_i & gnt_o))) |=> (gnt_vld_o && $stable(gnt_o)));
endmodule

// File: rtl/prio_slave_arb.sv
module prio_slave_arb #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_MST-1:0]        req_i,
  input  logic [N_MST-1:0]        done_i,
  input  logic                    cfg_we_i,
  input  logic [N_MST*PRIO_W-1:0] cfg_prio_i,
  output logic [N_MST*PRIO_W-1:0] prio_o,
  output logic [N_MST-1:0]        gnt_o,
  output logic                    gnt_vld_o
);
  logic [N_MST-1:0] elig;
  logic [N_MST-1:0] win;
  logic             win_vld;

  prio_cfg_reg #(.N_MST(N_MST), .PRIO_W(PRIO_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_prio_i),
    .prio_o  (prio_o)
  );

  prio_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W)) u_pick (
    .req_i     (req_i),
    .prio_i    (prio_o),
    .elig_o    (elig),
    .win_o     (win),
    .win_vld_o (win_vld)
  );

  grant_hold #(.N_MST(N_MST)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .win_i     (win),
    .win_vld_i (win_vld),
    .done_i    (done_i),
    .gnt_o     (gnt_o),
    .gnt_vld_o (gnt_vld_o)
  );

  // A new owner was requesting with a non-zero field on the previous edge (R2, R3).
  assert_new_owner_eligible_R3: assert property (@(posedge clk) disable iff (rst)
    (gnt_vld_o && (gnt_o != $past(gnt_o))) |-> |(gnt_o & $past(elig)));

  // Free port and no eligible requester: stays without owner (R7).
  assert_idle_no_grant_R7: assert property (@(posedge clk) disable iff (rst)
    (!gnt_vld_o && (elig == '0)) |=> !gnt_vld_o);
endmodule

// File: tb/test_prio_slave_arb.sv
module test_prio_slave_arb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  done = '0;
  logic          cfg_we = 1'b0;
  logic [N*PW-1:0] cfg_prio = '0;
  logic [N*PW-1:0] prio;
  logic [N-1:0]  gnt;
  logic          gnt_vld;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_slave_arb #(.N_MST(N), .PRIO_W(PW)) i_prio_slave_arb (
    .clk(clk), .rst(rst), .req_i(req), .done_i(done),
    .cfg_we_i(cfg_we), .cfg_prio_i(cfg_prio), .prio_o(prio),
    .gnt_o(gnt), .gnt_vld_o(gnt_vld)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_prio(input logic [N*PW-1:0] v);
    cfg_prio = v;
    cfg_we   = 1'b1;
    step();
    cfg_we   = 1'b0;
  endtask

  // Let the current owner finish with no further requests.
  task automatic release_all();
    req  = '0;
    done = gnt;
    step();
    done = '0;
  endtask

  task automatic t_reset();
    check("R1 grant", 32'(gnt), 32'h0);
    check("R1 valid", 32'(gnt_vld), 32'h0);
    check("R1 prio default", 32'(prio), 32'(12'b100_011_010_001));
  endtask

  task automatic t_basic_and_handover();
    req = 4'b0101;
    step();
    check("R2 grant to master2", 32'(gnt), 32'h4);
    check("R2 valid", 32'(gnt_vld), 32'h1);
    req  = 4'b0001;
    done = 4'b0100;
    step();
    done = '0;
    check("R6 handover to master0", 32'(gnt), 32'h1);
    req  = '0;
    done = 4'b0001;
    step();
    done = '0;
    check("R7 no requester grant", 32'(gnt), 32'h0);
    check("R7 no requester valid", 32'(gnt_vld), 32'h0);
  endtask

  task automatic t_zero_prio();
    write_prio(12'b000_011_010_001);
    check("R8 prio readback", 32'(prio), 32'(12'b000_011_010_001));
    req = 4'b1000;
    step();
    check("R3 zero-prio sole requester", 32'(gnt_vld), 32'h0);
    step();
    check("R3 still no grant", 32'(gnt), 32'h0);
    req = 4'b1001;
    step();
    check("R3 master3 skipped", 32'(gnt), 32'h1);
    release_all();
  endtask

  task automatic t_tie();
    write_prio(12'b010_010_001_010);
    req = 4'b1101;
    step();
    check("R4 tie lowest index", 32'(gnt), 32'h1);
    release_all();
    req = 4'b1100;
    step();
    check("R4 tie master2 over master3", 32'(gnt), 32'h4);
    release_all();
  endtask

  task automatic t_hold_and_late_write();
    write_prio(12'b100_011_010_001);
    req = 4'b0001;
    step();
    check("R5 initial owner", 32'(gnt), 32'h1);
    req  = 4'b1001;
    done = 4'b1000;
    step();
    done = '0;
    check("R5 foreign done ignored", 32'(gnt), 32'h1);
    step();
    check("R5 no preemption", 32'(gnt), 32'h1);
    write_prio(12'b100_011_010_000);
    check("R8 write during hold keeps owner", 32'(gnt), 32'h1);
    done = 4'b0001;
    step();
    done = '0;
    check("R8 new value used at next arbitration", 32'(gnt), 32'h8);
    release_all();
  endtask

  task automatic t_value_order();
    write_prio(12'b001_001_100_001);
    req = 4'b1010;
    step();
    check("R10 larger value wins", 32'(gnt), 32'h2);
    release_all();
    write_prio(12'b111_001_001_110);
    req = 4'b1001;
    step();
    check("R10 high index with larger value", 32'(gnt), 32'h8);
    check("R9 single grant bit", 32'($countones(gnt)), 32'h1);
    release_all();
    check("R7 idle after release", 32'(gnt_vld), 32'h0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    step();
    step();
    rst = 1'b0;
    t_reset();
    t_basic_and_handover();
    t_zero_prio();
    t_tie();
    t_hold_and_late_write();
    t_value_order();
    finish_run();
  end
endmodule